// File: doc/BRIEF.md
# Aliased Dual-View Register File

This block holds eight 80-bit entries that two execution modes share. The floating-point view reaches the entries through a 3-bit stack-top pointer. A push moves the pointer down and a pop moves it up. A stack-relative index i selects the physical entry (top + i) mod 8. The packed-integer view reaches the same storage as eight 64-bit registers, selected by absolute index. Each of these registers is the low 64 bits of its entry.

Both views read and write one array, so a write through one view shows up on the next read through the other. An integer-view write fills the upper 16 bits of the entry with ones. Such an entry therefore looks like a special value (exponent all ones) to the floating-point view. A flag on each floating-point read port reports this case.

The block keeps one valid bit per entry. Any integer-view access switches the file into integer mode: the pointer returns to 0 and every valid bit is set. A separate clear input empties all valid bits and returns the file to floating-point mode.

Top module: `dual_view_regfile`

## Requirements
- R1: After reset, every entry holds zero, `fp_top` is 0, `tag_valid` is all zeros and `int_mode` is 0.
- R2: `int_rd_data_a`/`int_rd_data_b` show bits 63:0 of physical entry `int_rd_idx_a`/`int_rd_idx_b` in the same cycle. Reading without `int_rd_en` changes no state.
- R3: An integer write (`int_wr_en`) stores `int_wr_data` in bits 63:0 of entry `int_wr_idx` and all ones in bits 79:64. Both views see the new value from the next cycle.
- R4: In the floating-point view, relative index i (on reads and on `fp_wr_idx`) selects physical entry (`fp_top` + i) mod 8, using the pointer value before this cycle's update.
- R5: `stk_op` 2'b01 (push) decrements `fp_top` mod 8. `stk_op` 2'b10 (pop) increments `fp_top` mod 8 and clears the valid bit of the entry at the old top. Codes 2'b00 and 2'b11 leave the pointer unchanged.
- R6: A floating-point write sets the valid bit of its target entry, unless a pop in the same cycle empties that same entry.
- R7: A cycle with `int_wr_en` or `int_rd_en` high sets `fp_top` to 0, sets all valid bits and raises `int_mode` in the next cycle. This overrides any stack operation.
- R8: `clr_state` empties all valid bits and clears `int_mode` in the next cycle. It overrides an integer access for the tags and the mode, but not for the pointer reset.
- R9: A read in the same cycle as a write to the same entry returns the old contents. Entries that are not written keep their value.
- R10: When an integer write and a floating-point write target the same physical entry in one cycle, the integer write wins.
- R11: `fp_rd_special_a`/`fp_rd_special_b` are high exactly when bits 78:64 (the exponent field) of the entry read are all ones.
- R12: `fp_rd_full_a`/`fp_rd_full_b` show the valid bit of the physical entry selected by that port.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| stk_op | input | 2 | Stack pointer update: 00 hold, 01 push, 10 pop, 11 hold |
| fp_wr_en | input | 1 | Floating-point view write enable |
| fp_wr_idx | input | 3 | Stack-relative write index |
| fp_wr_data | input | 80 | Floating-point write data |
| fp_rd_idx_a | input | 3 | Stack-relative index, read port A |
| fp_rd_idx_b | input | 3 | Stack-relative index, read port B |
| fp_rd_data_a | output | 80 | Entry read through port A |
| fp_rd_data_b | output | 80 | Entry read through port B |
| fp_rd_special_a | output | 1 | Exponent field of port A entry is all ones |
| fp_rd_special_b | output | 1 | Exponent field of port B entry is all ones |
| fp_rd_full_a | output | 1 | Valid bit of port A entry |
| fp_rd_full_b | output | 1 | Valid bit of port B entry |
| int_wr_en | input | 1 | Integer view write enable |
| int_wr_idx | input | 3 | Absolute integer write index |
| int_wr_data | input | 64 | Integer write data |
| int_rd_en | input | 1 | Integer read access strobe (switches mode) |
| int_rd_idx_a | input | 3 | Absolute index, integer read port A |
| int_rd_idx_b | input | 3 | Absolute index, integer read port B |
| int_rd_data_a | output | 64 | Low 64 bits of entry, port A |
| int_rd_data_b | output | 64 | Low 64 bits of entry, port B |
| clr_state | input | 1 | Empty all valid bits, return to floating-point mode |
| fp_top | output | 3 | Current stack-top pointer |
| tag_valid | output | 8 | Valid bit per physical entry |
| int_mode | output | 1 | High while the file is in integer mode |

## Verification
Read data, the special flag and the valid bit on the read ports are combinational from the stored state. They are due in the same cycle the indices are applied, and they reflect contents from before that cycle's edge. Storage contents, `fp_top`, `tag_valid` and `int_mode` change on the clock edge that samples the request and are due one cycle later. The bench drives inputs just after a falling edge. One time unit later it compares every output against a reference model that still holds the state from before the coming edge. It advances the model only after the rising edge, so each result is checked in exactly the cycle it is due.

// File: rtl/dvrf_pkg.sv
package dvrf_pkg;
    localparam int NUM_ENT = 8;
    localparam int INT_W   = 64;
    localparam int EXT_W   = 16;

    typedef enum logic [1:0] {
        STK_HOLD = 2'b00,
        STK_PUSH = 2'b01,
        STK_POP  = 2'b10,
        STK_RSVD = 2'b11
    } stk_op_e;
endpackage

// File: rtl/dvrf_stack_ctl.sv
module dvrf_stack_ctl #(
    parameter int NUM_ENT = dvrf_pkg::NUM_ENT,
    parameter int IDX_W   = $clog2(NUM_ENT)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [1:0]         stk_op,
    input  logic               fp_we,
    input  logic [IDX_W-1:0]   fp_wr_phys,
    input  logic               int_acc,
    input  logic               clr,
    output logic [IDX_W-1:0]   top,
    output logic [NUM_ENT-1:0] tags,
    output logic               int_mode
);
    import dvrf_pkg::*;

    typedef struct packed {
        logic [IDX_W-1:0]   top;
        logic [NUM_ENT-1:0] tags;
        logic               int_mode;
    } ctl_t;

    ctl_t st_d, st_q;

    initial assert (NUM_ENT == (1 << IDX_W));

    always_comb begin
        st_d = st_q;
        if (fp_we) st_d.tags[fp_wr_phys] = 1'b1;
        case (stk_op)
            STK_PUSH: st_d.top = st_q.top - IDX_W'(1);
            STK_POP: begin
                st_d.top = st_q.top + IDX_W'(1);
                st_d.tags[st_q.top] = 1'b0;
            end
            default: ;
        endcase
        if (int_acc) begin
            st_d.top      = '0;
            st_d.tags     = '1;
            st_d.int_mode = 1'b1;
        end
        if (clr) begin
            st_d.tags     = '0;
            st_d.int_mode = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign top      = st_q.top;
    assign tags     = st_q.tags;
    assign int_mode = st_q.int_mode;

    assert_push_dec_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (stk_op == STK_PUSH && !int_acc) |=> top == $past(top) - IDX_W'(1));

    assert_pop_empty_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (stk_op == STK_POP && !int_acc && !clr) |=> !tags[$past(top)]);

    assert_int_switch_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (int_acc && !clr) |=> (top == '0 && tags == '1 && int_mode));

    assert_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (tags == '0 && !int_mode));
endmodule

// File: rtl/dvrf_store.sv
module dvrf_store #(
    parameter int NUM_ENT = dvrf_pkg::NUM_ENT,
    parameter int INT_W   = dvrf_pkg::INT_W,
    parameter int EXT_W   = dvrf_pkg::EXT_W,
    parameter int ENT_W   = INT_W + EXT_W,
    parameter int IDX_W   = $clog2(NUM_ENT)
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           fp_we,
    input  logic [IDX_W-1:0]               fp_phys,
    input  logic [ENT_W-1:0]               fp_data,
    input  logic                           int_we,
    input  logic [IDX_W-1:0]               int_idx,
    input  logic [INT_W-1:0]               int_data,
    output logic [NUM_ENT-1:0][ENT_W-1:0]  ents
);
    logic [NUM_ENT-1:0][ENT_W-1:0] ent_d, ent_q;

    always_comb begin
        ent_d = ent_q;
        if (fp_we)  ent_d[fp_phys] = fp_data;
        if (int_we) ent_d[int_idx] = {{EXT_W{1'b1}}, int_data};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ent_q <= '0;
        else        ent_q <= ent_d;
    end

    assign ents = ent_q;

    assert_int_ext_ones_R3: assert property (@(posedge clk) disable iff (!rst_n)
        int_we |=> (ents[$past(int_idx)][ENT_W-1:INT_W] == '1 &&
                    ents[$past(int_idx)][INT_W-1:0] == $past(int_data)));

    assert_int_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (int_we && fp_we && fp_phys == int_idx) |=>
            ents[$past(int_idx)][INT_W-1:0] == $past(int_data));

    for (genvar e = 0; e < NUM_ENT; e++) begin : g_hold
        assert_untouched_R9: assert property (@(posedge clk) disable iff (!rst_n)
            (!(fp_we && fp_phys == IDX_W'(e)) && !(int_we && int_idx == IDX_W'(e)))
                |=> $stable(ents[e]));
    end
endmodule

// File: rtl/dvrf_fp_port.sv
module dvrf_fp_port #(
    parameter int NUM_ENT = dvrf_pkg::NUM_ENT,
    parameter int INT_W   = dvrf_pkg::INT_W,
    parameter int EXT_W   = dvrf_pkg::EXT_W,
    parameter int ENT_W   = INT_W + EXT_W,
    parameter int IDX_W   = $clog2(NUM_ENT)
) (
    input  logic [IDX_W-1:0]              top,
    input  logic [IDX_W-1:0]              rel,
    input  logic [NUM_ENT-1:0][ENT_W-1:0] ents,
    input  logic [NUM_ENT-1:0]            tags,
    output logic [ENT_W-1:0]              data,
    output logic                          special,
    output logic                          full
);
    localparam int EXP_LO = INT_W;
    localparam int EXP_HI = ENT_W - 2;

    logic [IDX_W-1:0] phys;

    always_comb begin
        phys    = top + rel;
        data    = ents[phys];
        special = &data[EXP_HI:EXP_LO];
        full    = tags[phys];
    end
endmodule

// File: rtl/dual_view_regfile.sv
module dual_view_regfile #(
    parameter int NUM_ENT = dvrf_pkg::NUM_ENT,
    parameter int INT_W   = dvrf_pkg::INT_W,
    parameter int EXT_W   = dvrf_pkg::EXT_W,
    parameter int ENT_W   = INT_W + EXT_W,
    parameter int IDX_W   = $clog2(NUM_ENT)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [1:0]         stk_op,
    input  logic               fp_wr_en,
    input  logic [IDX_W-1:0]   fp_wr_idx,
    input  logic [ENT_W-1:0]   fp_wr_data,
    input  logic [IDX_W-1:0]   fp_rd_idx_a,
    input  logic [IDX_W-1:0]   fp_rd_idx_b,
    output logic [ENT_W-1:0]   fp_rd_data_a,
    output logic [ENT_W-1:0]   fp_rd_data_b,
    output logic               fp_rd_special_a,
    output logic               fp_rd_special_b,
    output logic               fp_rd_full_a,
    output logic               fp_rd_full_b,
    input  logic               int_wr_en,
    input  logic [IDX_W-1:0]   int_wr_idx,
    input  logic [INT_W-1:0]   int_wr_data,
    input  logic               int_rd_en,
    input  logic [IDX_W-1:0]   int_rd_idx_a,
    input  logic [IDX_W-1:0]   int_rd_idx_b,
    output logic [INT_W-1:0]   int_rd_data_a,
    output logic [INT_W-1:0]   int_rd_data_b,
    input  logic               clr_state,
    output logic [IDX_W-1:0]   fp_top,
    output logic [NUM_ENT-1:0] tag_valid,
    output logic               int_mode
);
    logic [NUM_ENT-1:0][ENT_W-1:0] ents;
    logic [IDX_W-1:0]              wr_phys;
    logic                          int_acc;

    assign int_acc = int_wr_en | int_rd_en;
    assign wr_phys = fp_top + fp_wr_idx;

    dvrf_stack_ctl #(.NUM_ENT(NUM_ENT), .IDX_W(IDX_W)) u_ctl (
        .clk        (clk),
        .rst_n      (rst_n),
        .stk_op     (stk_op),
        .fp_we      (fp_wr_en),
        .fp_wr_phys (wr_phys),
        .int_acc    (int_acc),
        .clr        (clr_state),
        .top        (fp_top),
        .tags       (tag_valid),
        .int_mode   (int_mode)
    );

    dvrf_store #(.NUM_ENT(NUM_ENT), .INT_W(INT_W), .EXT_W(EXT_W),
                 .ENT_W(ENT_W), .IDX_W(IDX_W)) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .fp_we    (fp_wr_en),
        .fp_phys  (wr_phys),
        .fp_data  (fp_wr_data),
        .int_we   (int_wr_en),
        .int_idx  (int_wr_idx),
        .int_data (int_wr_data),
        .ents     (ents)
    );

    dvrf_fp_port #(.NUM_ENT(NUM_ENT), .INT_W(INT_W), .EXT_W(EXT_W),
                   .ENT_W(ENT_W), .IDX_W(IDX_W)) u_port_a (
        .top     (fp_top),
        .rel     (fp_rd_idx_a),
        .ents    (ents),
        .tags    (tag_valid),
        .data    (fp_rd_data_a),
        .special (fp_rd_special_a),
        .full    (fp_rd_full_a)
    );

    dvrf_fp_port #(.NUM_ENT(NUM_ENT), .INT_W(INT_W), .EXT_W(EXT_W),
                   .ENT_W(ENT_W), .IDX_W(IDX_W)) u_port_b (
        .top     (fp_top),
        .rel     (fp_rd_idx_b),
        .ents    (ents),
        .tags    (tag_valid),
        .data    (fp_rd_data_b),
        .special (fp_rd_special_b),
        .full    (fp_rd_full_b)
    );

    assign int_rd_data_a = ents[int_rd_idx_a][INT_W-1:0];
    assign int_rd_data_b = ents[int_rd_idx_b][INT_W-1:0];

    // R4: both views must agree whenever they land on the same physical entry
    always_comb begin
        if (rst_n && IDX_W'(fp_top + fp_rd_idx_a) == int_rd_idx_a)
            assert_alias_R4: assert (int_rd_data_a == fp_rd_data_a[INT_W-1:0]);
    end
endmodule

// File: tb/dual_view_regfile_bench.sv
module dual_view_regfile_bench;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  stk_op = '0;
    logic        fp_wr_en = 1'b0;
    logic [2:0]  fp_wr_idx = '0;
    logic [79:0] fp_wr_data = '0;
    logic [2:0]  fp_rd_idx_a = '0, fp_rd_idx_b = '0;
    logic [79:0] fp_rd_data_a, fp_rd_data_b;
    logic        fp_rd_special_a, fp_rd_special_b, fp_rd_full_a, fp_rd_full_b;
    logic        int_wr_en = 1'b0;
    logic [2:0]  int_wr_idx = '0;
    logic [63:0] int_wr_data = '0;
    logic        int_rd_en = 1'b0;
    logic [2:0]  int_rd_idx_a = '0, int_rd_idx_b = '0;
    logic [63:0] int_rd_data_a, int_rd_data_b;
    logic        clr_state = 1'b0;
    logic [2:0]  fp_top;
    logic [7:0]  tag_valid;
    logic        int_mode;

    int total = 0;
    int bad   = 0;

    logic [79:0] mmem [8];
    logic [2:0]  mtop;
    logic [7:0]  mtags;
    logic        mmode;

    always #(CLK_PERIOD/2) clk = ~clk;

    dual_view_regfile u_dual_view_regfile (
        .clk(clk), .rst_n(rst_n), .stk_op(stk_op),
        .fp_wr_en(fp_wr_en), .fp_wr_idx(fp_wr_idx), .fp_wr_data(fp_wr_data),
        .fp_rd_idx_a(fp_rd_idx_a), .fp_rd_idx_b(fp_rd_idx_b),
        .fp_rd_data_a(fp_rd_data_a), .fp_rd_data_b(fp_rd_data_b),
        .fp_rd_special_a(fp_rd_special_a), .fp_rd_special_b(fp_rd_special_b),
        .fp_rd_full_a(fp_rd_full_a), .fp_rd_full_b(fp_rd_full_b),
        .int_wr_en(int_wr_en), .int_wr_idx(int_wr_idx), .int_wr_data(int_wr_data),
        .int_rd_en(int_rd_en), .int_rd_idx_a(int_rd_idx_a), .int_rd_idx_b(int_rd_idx_b),
        .int_rd_data_a(int_rd_data_a), .int_rd_data_b(int_rd_data_b),
        .clr_state(clr_state), .fp_top(fp_top), .tag_valid(tag_valid), .int_mode(int_mode)
    );

    task automatic check(input bit ok, input string req, input logic [79:0] act, input logic [79:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=%h exp=%h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic idle();
        stk_op = 2'b00; fp_wr_en = 0; int_wr_en = 0; int_rd_en = 0; clr_state = 0;
    endtask

    task automatic compare_all();
        logic [2:0]  pa, pb;
        logic [79:0] ea, eb;
        pa = mtop + fp_rd_idx_a;
        pb = mtop + fp_rd_idx_b;
        ea = mmem[pa];
        eb = mmem[pb];
        check(fp_rd_data_a === ea, "R4 fp port a", fp_rd_data_a, ea);
        check(fp_rd_data_b === eb, "R4 fp port b", fp_rd_data_b, eb);
        check(fp_rd_special_a === (&ea[78:64]), "R11 special a", 80'(fp_rd_special_a), 80'(&ea[78:64]));
        check(fp_rd_special_b === (&eb[78:64]), "R11 special b", 80'(fp_rd_special_b), 80'(&eb[78:64]));
        check(fp_rd_full_a === mtags[pa], "R12 full a", 80'(fp_rd_full_a), 80'(mtags[pa]));
        check(fp_rd_full_b === mtags[pb], "R12 full b", 80'(fp_rd_full_b), 80'(mtags[pb]));
        check(int_rd_data_a === mmem[int_rd_idx_a][63:0], "R2 int port a", 80'(int_rd_data_a), 80'(mmem[int_rd_idx_a][63:0]));
        check(int_rd_data_b === mmem[int_rd_idx_b][63:0], "R2 int port b", 80'(int_rd_data_b), 80'(mmem[int_rd_idx_b][63:0]));
        check(fp_top === mtop, "R5 top", 80'(fp_top), 80'(mtop));
        check(tag_valid === mtags, "R6 tags", 80'(tag_valid), 80'(mtags));
        check(int_mode === mmode, "R7 mode", 80'(int_mode), 80'(mmode));
    endtask

    task automatic model_update();
        logic [2:0] ph, ntop;
        logic [7:0] nt;
        logic       nm;
        ph = mtop + fp_wr_idx;
        ntop = mtop; nt = mtags; nm = mmode;
        if (fp_wr_en) mmem[ph] = fp_wr_data;
        if (int_wr_en) mmem[int_wr_idx] = {16'hFFFF, int_wr_data};
        if (fp_wr_en) nt[ph] = 1'b1;
        if (stk_op == 2'b01) ntop = mtop - 3'd1;
        else if (stk_op == 2'b10) begin ntop = mtop + 3'd1; nt[mtop] = 1'b0; end
        if (int_wr_en || int_rd_en) begin ntop = '0; nt = '1; nm = 1'b1; end
        if (clr_state) begin nt = '0; nm = 1'b0; end
        mtop = ntop; mtags = nt; mmode = nm;
    endtask

    // inputs are set just after a falling edge; outputs checked 1 unit later
    task automatic step();
        #1;
        compare_all();
        @(posedge clk);
        model_update();
        @(negedge clk);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        bad++;
        total++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [63:0] old_v;
        for (int i = 0; i < 8; i++) mmem[i] = '0;
        mtop = '0; mtags = '0; mmode = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state, read every entry without an access strobe
        for (int i = 0; i < 8; i++) begin
            int_rd_idx_a = 3'(i); fp_rd_idx_a = 3'(i);
            #1;
            check(int_rd_data_a === '0, "R1 reset entry", 80'(int_rd_data_a), 80'(0));
            check(fp_top === 3'd0 && tag_valid === 8'h00 && int_mode === 1'b0,
                  "R1 reset ctl", 80'({fp_top, tag_valid, int_mode}), 80'(0));
            step();
        end

        // R3/R9: integer write sweep with same-cycle reads of the target
        for (int i = 0; i < 8; i++) begin
            idle();
            int_wr_en = 1; int_wr_idx = 3'(i);
            int_wr_data = 64'h0123_4567_89AB_CDEF ^ (64'(i) * 64'h1111_1111_1111_1111);
            int_rd_idx_a = 3'(i); int_rd_idx_b = 3'(7 - i);
            old_v = mmem[i][63:0];
            #1;
            check(int_rd_data_a === old_v, "R9 old value on same-cycle read", 80'(int_rd_data_a), 80'(old_v));
            step();
        end
        idle();
        for (int i = 0; i < 8; i++) begin
            fp_rd_idx_a = 3'(i); fp_rd_idx_b = 3'((i + 3) % 8);
            #1;
            check(fp_rd_data_a[79:64] === 16'hFFFF, "R3 upper ones", 80'(fp_rd_data_a[79:64]), 80'hFFFF);
            check(fp_rd_special_a === 1'b1, "R11 int entry special", 80'(fp_rd_special_a), 80'(1));
            check(int_mode === 1'b1 && fp_top === 3'd0 && tag_valid === 8'hFF, "R7 int mode",
                  80'({fp_top, tag_valid, int_mode}), 80'({3'd0, 8'hFF, 1'b1}));
            step();
        end

        // R8: clear
        idle(); clr_state = 1; step(); idle();
        #1;
        check(tag_valid === 8'h00 && int_mode === 1'b0, "R8 clear", 80'({tag_valid, int_mode}), 80'(0));
        step();

        // R5/R6/R4: push then write top of stack, all eight depths
        for (int i = 0; i < 8; i++) begin
            idle(); stk_op = 2'b01; step();
            idle(); fp_wr_en = 1; fp_wr_idx = 3'd0;
            fp_wr_data = {16'h3FF0 + 16'(i), 64'hA5A5_0000_0000_0000 + 64'(i)};
            step();
            idle(); fp_rd_idx_a = 3'd0; fp_rd_idx_b = 3'd1;
            #1;
            check(fp_top === 3'(8 - i - 1) || (i == 7 && fp_top === 3'd0), "R5 push depth",
                  80'(fp_top), 80'(3'(7 - i)));
            check(fp_rd_full_a === 1'b1, "R6 tag set by write", 80'(fp_rd_full_a), 80'(1));
            check(fp_rd_special_a === 1'b0, "R11 normal value", 80'(fp_rd_special_a), 80'(0));
            step();
        end
        // R5: pops empty the old top
        for (int i = 0; i < 4; i++) begin
            idle(); stk_op = 2'b10; step();
        end
        // R5: reserved code holds
        idle(); stk_op = 2'b11; step();

        // R10: int and fp write collide on one entry
        idle(); fp_wr_en = 1; fp_wr_idx = 3'd0; fp_wr_data = 80'h1234_5555_5555_5555_5555;
        int_wr_en = 1; int_wr_idx = mtop; int_wr_data = 64'hDEAD_BEEF_0BAD_F00D;
        step();
        idle(); int_rd_idx_a = int_wr_idx;
        #1;
        check(int_rd_data_a === 64'hDEAD_BEEF_0BAD_F00D, "R10 int wins", 80'(int_rd_data_a), 80'(64'hDEAD_BEEF_0BAD_F00D));
        step();

        // R8 over R7: clear together with an int read
        idle(); stk_op = 2'b01; step();
        idle(); clr_state = 1; int_rd_en = 1; stk_op = 2'b01; step();
        idle();
        #1;
        check(fp_top === 3'd0 && tag_valid === 8'h00 && int_mode === 1'b0, "R8 priority over R7",
              80'({fp_top, tag_valid, int_mode}), 80'(0));
        step();

        // R6: pop and write to the same entry in one cycle
        idle(); fp_wr_en = 1; fp_wr_idx = 3'd0; fp_wr_data = 80'h4000_8000_0000_0000_0000; stk_op = 2'b10;
        step();

        // mixed sweep over all inputs
        for (int n = 0; n < 3000; n++) begin
            logic [31:0] r, r2;
            r = $urandom; r2 = $urandom;
            fp_wr_en = r[0]; fp_wr_idx = r[3:1];
            fp_wr_data = {r2[15:0], $urandom, $urandom};
            if (r[4]) fp_wr_data[78:64] = '1;
            stk_op = r[6:5];
            int_wr_en = (r[9:7] == 3'd0);
            int_rd_en = (r[12:10] == 3'd0);
            clr_state = (r[17:13] == 5'd0);
            int_wr_idx = r[20:18]; int_wr_data = {$urandom, $urandom};
            int_rd_idx_a = r[23:21]; int_rd_idx_b = r[26:24];
            fp_rd_idx_a = r[29:27]; fp_rd_idx_b = r2[18:16];
            step();
        end
        idle(); step();

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule